// File: doc/BRIEF.md
# Periodic Up-Counter System Timer

This block is a processor system timer built around a free-running up-counter. The counter cannot be stopped by software. It advances by one on every enabled clock. When it equals a programmable terminal value it returns to zero and latches a sticky event flag.

Software reaches three registers over a small synchronous bus: the running count, a control word and the terminal value. The control word holds four bits:

- an interrupt enable;
- a bit that freezes counting while the processor reports a halt;
- a watchdog selector;
- the event flag.

In normal use the flag, qualified by the enable, drives a level interrupt line. In watchdog mode the same event instead produces a single-cycle reset request, and the interrupt line stays low.

A typical driver clears the control word and the count, programs the terminal value to one tick minus one, and then sets the enable. The tick handler acknowledges each event by writing the control word with the flag bit at zero. Tick-skipping idle schemes load a longer terminal value, or load a remainder into the count, without stopping the counter.

Top module: `upcount_sys_timer`

## Requirements
- R1: After reset the count reads 0, the control word reads 0, the terminal value reads all-ones, `irq` and `wdog_rst` are low, and address 3 reads 0. The address map is 0 = count, 1 = control, 2 = terminal value. Control bits are: bit 0 interrupt enable, bit 1 halt gating, bit 2 watchdog mode, bit 3 event flag. All higher control bits read 0.
- R2: On every enabled cycle without a count write, the count grows by one. If the count equals the terminal value L, it goes to 0 instead, so the period is L+1 cycles (L = 0 keeps the count at 0).
- R3: The compare is an equality compare. A count above L keeps rising to all-ones, wraps to 0 without setting the flag, and is then compared again.
- R4: While control bit 1 is set and `cpu_halt` is high, the count holds its value. While bit 1 is clear, `cpu_halt` has no effect.
- R5: A wrap sets the event flag on the same clock edge. The flag stays set until a control write with bit 3 equal to 0. A control write with bit 3 equal to 1 never sets the flag. A wrap in the same cycle as a clearing write leaves the flag set.
- R6: With watchdog mode off, `irq` is high exactly when the enable and the flag are both set. Clearing the enable lowers `irq` but does not stop counting. After a write of 0 to both control and count, `irq` stays low.
- R7: With watchdog mode on, `irq` stays low. Each wrap raises `wdog_rst` for one cycle, on the edge that completes the wrap.
- R8: A count write loads the written value at the next edge, and counting resumes from it. If the write coincides with a compare match, the write wins: no wrap, and no flag is set.
- R9: A terminal-value write leaves the count unchanged. The new value is used from the next compare onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_halt | input | 1 | Processor halted indication |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one register per cycle |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |
| wdog_rst | output | 1 | One-cycle reset request in watchdog mode |

## Verification
The bench builds the timer with `CNT_W = 8` and halt gating enabled. The narrow counter puts the all-ones rollover of R3 and the reset terminal value within a few hundred cycles. With halt gating available, the bench can freeze the counter while it sets up each case. Every table row and corner case then starts from a known count at a known edge. The bench covers the collisions between a count write and a compare match, and between a flag-clearing write and a wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam int ADDR_W = 2;
   localparam int CTL_W  = 4;

   typedef enum logic [ADDR_W-1:0] {
      SEL_COUNT = 2'd0,
      SEL_CTL   = 2'd1,
      SEL_LIMIT = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;

   // packed MSB first: pend is bit 3, ie is bit 0
   typedef struct packed {
      logic pend;
      logic wd;
      logic nh;
      logic ie;
   } ctl_t;

endpackage

// File: rtl/tmr_ctl_reg.sv
module tmr_ctl_reg
   import tmr_pkg::*;
#(
   parameter bit HALT_GATE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctl,
   input  logic [CTL_W-1:0] wdata_ctl,
   input  logic             wrap_evt,
   output ctl_t             ctl
);

   logic ie_q, wd_q, nh_q, pend_q;
   logic clr_req;

   // a clearing write only drops the flag; a concurrent wrap re-sets it
   assign clr_req = wr_ctl & ~wdata_ctl[3];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q   <= 1'b0;
         wd_q   <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (wr_ctl) begin
            ie_q <= wdata_ctl[0];
            wd_q <= wdata_ctl[2];
         end
         pend_q <= wrap_evt | (pend_q & ~clr_req);
      end
   end

   generate
      if (HALT_GATE_EN) begin : g_halt_bit
         always_ff @(posedge clk) begin
            if (!rst_n)
               nh_q <= 1'b0;
            else if (wr_ctl)
               nh_q <= wdata_ctl[1];
         end
      end else begin : g_no_halt_bit
         assign nh_q = 1'b0;
      end
   endgenerate

   assign ctl = '{pend: pend_q, wd: wd_q, nh: nh_q, ie: ie_q};

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wr_cnt,
   input  logic             wr_lim,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] lim,
   output logic             wrap_evt
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic             at_lim;
   logic [CNT_W-1:0] cnt_nxt;

   assign at_lim   = (cnt == lim);
   assign wrap_evt = tick_en & ~wr_cnt & at_lim;

   always_comb begin
      cnt_nxt = cnt;
      if (wr_cnt)
         cnt_nxt = wdata;
      else if (tick_en)
         cnt_nxt = at_lim ? '0 : cnt + ONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         lim <= '1;
      end else begin
         cnt <= cnt_nxt;
         if (wr_lim)
            lim <= wdata;
      end
   end

endmodule

// File: rtl/tmr_irq_out.sv
module tmr_irq_out
   import tmr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  ctl_t ctl,
   input  logic wrap_evt,
   output logic irq,
   output logic wdog_rst
);

   logic rst_req_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         rst_req_q <= 1'b0;
      else
         rst_req_q <= wrap_evt & ctl.wd;
   end

   assign irq      = ctl.ie & ctl.pend & ~ctl.wd;
   assign wdog_rst = rst_req_q;

endmodule

// File: rtl/upcount_sys_timer.sv
module upcount_sys_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W        = 32,
   parameter bit HALT_GATE_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_halt,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [CNT_W-1:0]    bus_wdata,
   output logic [CNT_W-1:0]    bus_rdata,
   output logic                irq,
   output logic                wdog_rst
);

   localparam int PAD_W = CNT_W - CTL_W;

   generate
      if (CNT_W < 8 || CNT_W > 64) begin : g_bad_width
         $error("upcount_sys_timer: CNT_W must lie in 8..64");
      end
   endgenerate

   reg_sel_e         sel;
   logic             wr_cnt, wr_ctl, wr_lim;
   logic             tick_en;
   logic             wrap_evt;
   logic [CNT_W-1:0] cnt_q, lim_q;
   ctl_t             ctl;
   logic             ctl_ie, ctl_nh, ctl_wd, ctl_pend;

   assign sel    = reg_sel_e'(bus_addr);
   assign wr_cnt = bus_wr & (sel == SEL_COUNT);
   assign wr_ctl = bus_wr & (sel == SEL_CTL);
   assign wr_lim = bus_wr & (sel == SEL_LIMIT);

   assign ctl_ie   = ctl.ie;
   assign ctl_nh   = ctl.nh;
   assign ctl_wd   = ctl.wd;
   assign ctl_pend = ctl.pend;

   assign tick_en = ~(ctl_nh & cpu_halt);

   tmr_count_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .wr_cnt   (wr_cnt),
      .wr_lim   (wr_lim),
      .wdata    (bus_wdata),
      .cnt      (cnt_q),
      .lim      (lim_q),
      .wrap_evt (wrap_evt)
   );

   tmr_ctl_reg #(.HALT_GATE_EN(HALT_GATE_EN)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctl    (wr_ctl),
      .wdata_ctl (bus_wdata[CTL_W-1:0]),
      .wrap_evt  (wrap_evt),
      .ctl       (ctl)
   );

   tmr_irq_out u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl      (ctl),
      .wrap_evt (wrap_evt),
      .irq      (irq),
      .wdog_rst (wdog_rst)
   );

   always_comb begin
      case (sel)
         SEL_COUNT: bus_rdata = cnt_q;
         SEL_CTL:   bus_rdata = {{PAD_W{1'b0}}, ctl};
         SEL_LIMIT: bus_rdata = lim_q;
         default:   bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/tmr_sva.sv
module tmr_sva #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_halt,
   input logic [1:0]       bus_addr,
   input logic             bus_wr,
   input logic [CNT_W-1:0] bus_wdata,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] lim_q,
   input logic             ctl_nh,
   input logic             ctl_wd,
   input logic             ctl_pend,
   input logic             irq,
   input logic             wdog_rst
);

   logic cw, run, clr;
   assign cw  = bus_wr && (bus_addr == 2'd0);
   assign run = !(ctl_nh && cpu_halt);
   assign clr = bus_wr && (bus_addr == 2'd1) && !bus_wdata[3];

   assert_count_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cw |=> (cnt_q == $past(bus_wdata)));

   assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cw && !run) |=> $stable(cnt_q));

   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cw && run && cnt_q != lim_q) |=> (cnt_q == $past(cnt_q) + 1'b1));

   assert_count_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cw && run && cnt_q == lim_q) |=> (cnt_q == '0 && ctl_pend));

   assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_pend && !clr) |=> ctl_pend);

   assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wd |-> !irq);

   assert_irq_needs_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_pend |-> !irq);

   assert_wdog_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst |-> ($past(ctl_wd) && ctl_pend));

endmodule

bind upcount_sys_timer tmr_sva #(.CNT_W(CNT_W)) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_halt  (cpu_halt),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .cnt_q     (cnt_q),
   .lim_q     (lim_q),
   .ctl_nh    (ctl_nh),
   .ctl_wd    (ctl_wd),
   .ctl_pend  (ctl_pend),
   .irq       (irq),
   .wdog_rst  (wdog_rst)
);

// File: tb/sim_upcount_sys_timer.sv
`timescale 1ns/1ps
module sim_upcount_sys_timer;

   localparam int W = 8;

   typedef struct packed {
      logic [7:0] lim;
      logic [7:0] run;
      logic       ie;
      logic       wd;
      logic [7:0] ecnt;
      logic       epend;
      logic       eirq;
   } vec_t;

   // R2 R5 R6 rows: terminal value, cycles run, enable, watchdog -> count, flag, irq
   localparam vec_t VECS [8] = '{
      '{8'd4,   8'd3,  1'b0, 1'b0, 8'd3,  1'b0, 1'b0},
      '{8'd4,   8'd5,  1'b1, 1'b0, 8'd0,  1'b1, 1'b1},
      '{8'd4,   8'd7,  1'b1, 1'b0, 8'd2,  1'b1, 1'b1},
      '{8'd0,   8'd3,  1'b0, 1'b0, 8'd0,  1'b1, 1'b0},
      '{8'd9,   8'd9,  1'b1, 1'b0, 8'd9,  1'b0, 1'b0},
      '{8'd9,   8'd10, 1'b1, 1'b1, 8'd0,  1'b1, 1'b0},
      '{8'd255, 8'd20, 1'b0, 1'b0, 8'd20, 1'b0, 1'b0},
      '{8'd2,   8'd8,  1'b0, 1'b0, 8'd2,  1'b1, 1'b0}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cpu_halt = 1'b0;
   logic [1:0]   bus_addr = 2'd0;
   logic         bus_wr = 1'b0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic         irq, wdog_rst;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;
   logic [W-1:0] rv, keep;

   always #2.5 clk = ~clk;

   upcount_sys_timer #(.CNT_W(W), .HALT_GATE_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cpu_halt(cpu_halt),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq), .wdog_rst(wdog_rst)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, rv); chk("R1 count", rv, 8'd0);
      rd(2'd1, rv); chk("R1 ctl", rv, 8'd0);
      rd(2'd2, rv); chk("R1 limit", rv, 8'd255);
      rd(2'd3, rv); chk("R1 addr3", rv, 8'd0);
      chk("R1 irq", {7'd0, irq}, 8'd0);
      chk("R1 wdog", {7'd0, wdog_rst}, 8'd0);

      // R4 halt ignored while bit 1 clear
      cpu_halt = 1'b1;
      wr(2'd0, 8'd0);
      repeat (5) @(posedge clk);
      @(negedge clk);
      rd(2'd0, rv); chk("R4 halt ignored", rv, 8'd5);

      // R4 halt freezes while bit 1 set
      wr(2'd1, 8'h02);
      rd(2'd0, keep);
      repeat (4) @(negedge clk);
      rd(2'd0, rv); chk("R4 frozen", rv, keep);

      // R5 writing bit 3 as one does not set the flag
      wr(2'd1, 8'h0A);
      rd(2'd1, rv); chk("R5 no set by write", rv, 8'h02);

      // R5 wrap beats a concurrent clearing write
      wr(2'd2, 8'd3);
      wr(2'd0, 8'd3);
      @(negedge clk);
      cpu_halt = 1'b0; bus_addr = 2'd1; bus_wdata = 8'h02; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; cpu_halt = 1'b1;
      rd(2'd1, rv); chk("R5 set wins", rv, 8'h0A);
      rd(2'd0, rv); chk("R2 wrap to zero", rv, 8'd0);

      // R8 count write beats a match
      wr(2'd1, 8'h02);
      wr(2'd0, 8'd3);
      @(negedge clk);
      cpu_halt = 1'b0; bus_addr = 2'd0; bus_wdata = 8'd7; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; cpu_halt = 1'b1;
      rd(2'd0, rv); chk("R8 write wins", rv, 8'd7);
      rd(2'd1, rv); chk("R8 no flag", rv, 8'h02);

      // R9 terminal value change keeps count
      wr(2'd0, 8'd2);
      wr(2'd2, 8'd5);
      wr(2'd2, 8'd10);
      rd(2'd0, rv); chk("R9 count kept", rv, 8'd2);
      cpu_halt = 1'b0;
      repeat (8) @(posedge clk);
      @(negedge clk);
      rd(2'd0, rv); chk("R9 new limit reached", rv, 8'd10);
      rd(2'd1, rv); chk("R9 no early flag", rv, 8'h02);
      @(negedge clk);
      cpu_halt = 1'b1;
      rd(2'd0, rv); chk("R9 wrap at new limit", rv, 8'd0);
      rd(2'd1, rv); chk("R9 flag", rv, 8'h0A);

      // R3 above terminal value runs to all-ones
      wr(2'd1, 8'h02);
      wr(2'd2, 8'd3);
      wr(2'd0, 8'd250);
      cpu_halt = 1'b0;
      repeat (6) @(posedge clk);
      @(negedge clk);
      rd(2'd0, rv); chk("R3 rollover", rv, 8'd0);
      rd(2'd1, rv); chk("R3 no flag", rv, 8'h02);
      repeat (4) @(posedge clk);
      @(negedge clk);
      cpu_halt = 1'b1;
      rd(2'd0, rv); chk("R3 wrap after", rv, 8'd0);
      rd(2'd1, rv); chk("R3 flag after", rv, 8'h0A);

      // R7 watchdog pulse
      wr(2'd1, 8'h02);
      wr(2'd2, 8'd2);
      wr(2'd0, 8'd2);
      wr(2'd1, 8'h07);
      cpu_halt = 1'b0;
      @(negedge clk);
      cpu_halt = 1'b1;
      chk("R7 wdog high", {7'd0, wdog_rst}, 8'd1);
      chk("R7 irq low", {7'd0, irq}, 8'd0);
      @(negedge clk);
      chk("R7 wdog one cycle", {7'd0, wdog_rst}, 8'd0);

      // R6 enable gating
      wr(2'd1, 8'h0B);
      chk("R6 irq on", {7'd0, irq}, 8'd1);
      wr(2'd1, 8'h0A);
      chk("R6 irq off", {7'd0, irq}, 8'd0);
      wr(2'd1, 8'h00);
      wr(2'd0, 8'd0);
      wr(2'd1, 8'h00);
      chk("R6 init quiet", {7'd0, irq}, 8'd0);

      // table walk
      for (int i = 0; i < 8; i++) begin
         cpu_halt = 1'b1;
         wr(2'd1, 8'h02);
         wr(2'd2, VECS[i].lim);
         wr(2'd0, 8'd0);
         wr(2'd1, {4'd0, 1'b0, VECS[i].wd, 1'b1, VECS[i].ie});
         cpu_halt = 1'b0;
         repeat (int'(VECS[i].run)) @(posedge clk);
         @(negedge clk);
         cpu_halt = 1'b1;
         rd(2'd0, rv); chk($sformatf("R2 row %0d count", i), rv, VECS[i].ecnt);
         rd(2'd1, rv); chk($sformatf("R5 row %0d flag", i), {7'd0, rv[3]}, {7'd0, VECS[i].epend});
         chk($sformatf("R6 row %0d irq", i), {7'd0, irq}, {7'd0, VECS[i].eirq});
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule